// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a CPU core and decides when the core must leave its main flow to service an event. It gathers requests from external pins, a core timer and a set of peripheral sources. Each source owns a sticky pending flag, an enable bit and a level bit. The block combines these with a global enable and a peripheral enable to raise a single-cycle `irq_take` pulse, together with the vector address the core must jump to. The core pushes its own return address. It signals the end of a handler with `ret_strobe`, which re-arms the level that was just serviced.

The external pins pass through a two-flop synchronizer. A glitch filter then counts instruction-cycle ticks (`insn_end`), and a pin's new level is accepted only after it has stayed stable for `MIN_TICKS` ticks. A per-pin polarity bit chooses whether the rising or the falling transition sets the flag. Software configures the block through a small write port and observes it through a read port. Both ports use the same register select codes.

A sequencer with four states tracks the service depth. `ST_IDLE` means no handler is running. `ST_LO` means a low-level handler is running. `ST_HI` means a high-level handler is running, and in single-level mode every handler runs in this state. `ST_NEST` means a high-level handler has preempted a low-level one. The transitions are as follows:
- `ST_IDLE` moves to `ST_HI` when a high-level request is accepted, and to `ST_LO` when a low-level request is accepted.
- `ST_LO` moves to `ST_NEST` when a high-level request preempts it, and to `ST_IDLE` on a return.
- `ST_HI` moves to `ST_IDLE` on a return.
- `ST_NEST` moves to `ST_LO` on a return.

A return seen in `ST_IDLE` is ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the block holds the following values: the flags (select 0) read 0, the source enables (select 1) read 0, the control register (select 4) reads 0, every level bit (select 2) reads 1, every polarity bit (select 3) reads 1, and `irq_take` is low. Source indices are assigned in this order: 0 and 1 are the external pins, 2 is the core timer, and 3 to 5 are the peripheral requests `per_req[0..2]`.
- R2: Bit 3 of the control register selects the mode, and it is 0 for single-level mode. With bit 3 cleared, every accepted interrupt presents vector 0x0008.
- R3: A source is taken only when control bit 0 (the global/high enable) and the source's own enable bit are both set. Peripheral sources (index 3 and above) also need control bit 2 (the peripheral enable).
- R4: A flag is set by its source event and stays set until a software write to select 0 clears it. If a hardware event and a software write of 0 land in the same cycle, the flag ends up set. A handler that returns with its flag still set is taken again.
- R5: With control bit 3 set, a source whose level bit is 1 is high level and uses vector 0x0008. A source whose level bit is 0 is low level, uses vector 0x0018, and also needs control bit 1. When both levels are pending, the high level wins.
- R6: Taking a high-level interrupt, or any interrupt in single-level mode, clears control bit 0. Taking a low-level interrupt clears control bit 1. The matching return sets that bit again.
- R7: A high-level request preempts a running low-level handler. The first return then re-enables only bit 0, and the second return re-enables bit 1.
- R8: An interrupt is accepted only on a cycle with `insn_end` high. `irq_take` is high for exactly one cycle, and it is registered one clock after acceptance.
- R9: Polarity bit 1 makes a pin's rising edge set its flag, and polarity bit 0 makes its falling edge set the flag. The opposite transition sets nothing.
- R10: A pin level that changes for fewer than `MIN_TICKS` (default 2) consecutive ticks is rejected. A level held for `MIN_TICKS` ticks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| tmr_req | input | 1 | Core timer overflow event |
| per_req | input | NUM_PERIPH | Peripheral events (timers, serial transmit and receive) |
| insn_end | input | 1 | Instruction boundary and filter tick |
| ret_strobe | input | 1 | Return-from-interrupt from the core |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select (0 flags, 1 enables, 2 levels, 3 polarity, 4 control) |
| wr_data | input | NSRC | Write data |
| rd_sel | input | 3 | Read register select |
| rd_data | output | NSRC | Read data |
| irq_take | output | 1 | Interrupt accepted pulse |
| irq_vector | output | ADDR_W | Vector address valid with irq_take |

## Verification
Vector choice is tried three ways: with a lone request in single-level mode, with both levels pending at once, and with a high request that arrives while a low handler runs. Together these separate the fixed vector, the win of the high level, and preemption with unwinding in the right order. Gating is tried by withholding the global enable, the peripheral enable and the instruction boundary one at a time, which shows that each of them is required. Pin stimulus covers a rising edge, a falling edge under each polarity, a one-tick glitch and a pulse of exactly the minimum width. This shows apart the polarity handling, the filter threshold and an off-by-one in the filter.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_NEST = 2'd3
    } svc_state_e;

    localparam logic [2:0] SEL_FLAG = 3'd0;
    localparam logic [2:0] SEL_EN   = 3'd1;
    localparam logic [2:0] SEL_PRI  = 3'd2;
    localparam logic [2:0] SEL_POL  = 3'd3;
    localparam logic [2:0] SEL_CTL  = 3'd4;

    localparam int CTL_W     = 4;
    localparam int CTL_HI    = 0;
    localparam int CTL_LO    = 1;
    localparam int CTL_PERIPH = 2;
    localparam int CTL_MODE  = 3;

endpackage

// File: rtl/pin_edge_qual.sv
module pin_edge_qual #(
    parameter int MIN_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic tick,
    input  logic pol,
    output logic event_o
);
    localparam int CW = $clog2(MIN_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_TICKS - 1);

    logic          s1, s2, lvl;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            lvl <= 1'b0;
            cnt <= '0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            if (s2 == lvl) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == LAST) begin
                    lvl <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign event_o = (s2 != lvl) && tick && (cnt == LAST) && (s2 == pol);
endmodule

// File: rtl/irq_level_select.sv
module irq_level_select #(
    parameter int NSRC  = 6,
    parameter int NCORE = 3
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pri,
    input  logic [3:0]      ctl,
    output logic            hi_req,
    output logic            lo_req
);
    import prio_irq_pkg::*;

    localparam logic [NSRC-1:0] CORE_MASK = {{(NSRC-NCORE){1'b0}}, {NCORE{1'b1}}};

    logic [NSRC-1:0] pend;
    logic            mode;

    always_comb begin
        mode   = ctl[CTL_MODE];
        pend   = flags & en & (CORE_MASK | {NSRC{ctl[CTL_PERIPH]}});
        hi_req = ctl[CTL_HI] && (mode ? |(pend & pri) : |pend);
        lo_req = mode && ctl[CTL_HI] && ctl[CTL_LO] && |(pend & ~pri);
    end
endmodule

// File: rtl/irq_service_seq.sv
module irq_service_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic ret_strobe,
    input  logic hi_req,
    input  logic lo_req,
    output logic take_hi,
    output logic take_lo,
    output logic ret_hi,
    output logic ret_lo
);
    import prio_irq_pkg::*;

    svc_state_e state_q, state_d;
    logic       acc_hi, acc_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        acc_hi  = insn_end && hi_req && !ret_strobe &&
                  (state_q == ST_IDLE || state_q == ST_LO);
        acc_lo  = insn_end && lo_req && !hi_req && !ret_strobe &&
                  (state_q == ST_IDLE);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_hi)      state_d = ST_HI;
                else if (acc_lo) state_d = ST_LO;
            end
            ST_LO: begin
                if (ret_strobe)  state_d = ST_IDLE;
                else if (acc_hi) state_d = ST_NEST;
            end
            ST_HI:   if (ret_strobe) state_d = ST_IDLE;
            ST_NEST: if (ret_strobe) state_d = ST_LO;
        endcase
    end

    always_comb begin
        take_hi = acc_hi;
        take_lo = acc_lo;
        ret_hi  = 1'b0;
        ret_lo  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LO:   ret_lo = ret_strobe;
            ST_HI,
            ST_NEST: ret_hi = ret_strobe;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int             NUM_EXT    = 2,
    parameter int             NUM_PERIPH = 3,
    parameter int             MIN_TICKS  = 2,
    parameter int             ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] VEC_HI  = 16'h0008,
    parameter logic [ADDR_W-1:0] VEC_LO  = 16'h0018,
    localparam int            NSRC       = NUM_EXT + 1 + NUM_PERIPH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EXT-1:0]    ext_pin,
    input  logic                  tmr_req,
    input  logic [NUM_PERIPH-1:0] per_req,
    input  logic                  insn_end,
    input  logic                  ret_strobe,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [NSRC-1:0]       wr_data,
    input  logic [2:0]            rd_sel,
    output logic [NSRC-1:0]       rd_data,
    output logic                  irq_take,
    output logic [ADDR_W-1:0]     irq_vector
);
    import prio_irq_pkg::*;

    localparam int NCORE = NUM_EXT + 1;

    logic [NSRC-1:0]    flags_q, en_q, pri_q, hw_set;
    logic [NUM_EXT-1:0] pol_q, ext_ev;
    logic [CTL_W-1:0]   ctrl_q, ctrl_d;
    logic               hi_req, lo_req, take_hi, take_lo, ret_hi, ret_lo;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
        pin_edge_qual #(.MIN_TICKS(MIN_TICKS)) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[i]),
            .tick   (insn_end),
            .pol    (pol_q[i]),
            .event_o(ext_ev[i])
        );
    end

    assign hw_set = {per_req, tmr_req, ext_ev};

    irq_level_select #(.NSRC(NSRC), .NCORE(NCORE)) u_sel (
        .flags (flags_q),
        .en    (en_q),
        .pri   (pri_q),
        .ctl   (ctrl_q),
        .hi_req(hi_req),
        .lo_req(lo_req)
    );

    irq_service_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_end  (insn_end),
        .ret_strobe(ret_strobe),
        .hi_req    (hi_req),
        .lo_req    (lo_req),
        .take_hi   (take_hi),
        .take_lo   (take_lo),
        .ret_hi    (ret_hi),
        .ret_lo    (ret_lo)
    );

    // Sequencer updates to the level enables take precedence over a write.
    always_comb begin
        ctrl_d = (wr_en && wr_sel == SEL_CTL) ? wr_data[CTL_W-1:0] : ctrl_q;
        if (take_hi) ctrl_d[CTL_HI] = 1'b0;
        if (take_lo) ctrl_d[CTL_LO] = 1'b0;
        if (ret_hi)  ctrl_d[CTL_HI] = 1'b1;
        if (ret_lo)  ctrl_d[CTL_LO] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q    <= '0;
            en_q       <= '0;
            pri_q      <= '1;
            pol_q      <= '1;
            ctrl_q     <= '0;
            irq_take   <= 1'b0;
            irq_vector <= '0;
        end else begin
            flags_q <= ((wr_en && wr_sel == SEL_FLAG) ? wr_data : flags_q) | hw_set;
            if (wr_en && wr_sel == SEL_EN)  en_q  <= wr_data;
            if (wr_en && wr_sel == SEL_PRI) pri_q <= wr_data;
            if (wr_en && wr_sel == SEL_POL) pol_q <= wr_data[NUM_EXT-1:0];
            ctrl_q   <= ctrl_d;
            irq_take <= take_hi || take_lo;
            if (take_hi)      irq_vector <= VEC_HI;
            else if (take_lo) irq_vector <= VEC_LO;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_FLAG: rd_data = flags_q;
            SEL_EN:   rd_data = en_q;
            SEL_PRI:  rd_data = pri_q;
            SEL_POL:  rd_data = {{(NSRC-NUM_EXT){1'b0}}, pol_q};
            SEL_CTL:  rd_data = {{(NSRC-CTL_W){1'b0}}, ctrl_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int                NSRC   = 6,
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] VEC_HI = 16'h0008,
    parameter logic [ADDR_W-1:0] VEC_LO = 16'h0018
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_take,
    input logic [ADDR_W-1:0] irq_vector,
    input logic              insn_end,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [NSRC-1:0]   flags_q,
    input logic [3:0]        ctrl_q
);
    a_r8_take_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    a_r8_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(insn_end));

    a_r1_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vector == VEC_HI || irq_vector == VEC_LO));

    a_r2_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !$past(ctrl_q[3])) |-> irq_vector == VEC_HI);

    a_r6_hi_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector == VEC_HI) |-> !ctrl_q[0]);

    a_r6_lo_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vector == VEC_LO) |-> !ctrl_q[1]);

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && wr_sel == 3'd0) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_vector(irq_vector),
    .insn_end(insn_end), .wr_en(wr_en), .wr_sel(wr_sel),
    .flags_q(flags_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int NSRC  = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      ext_pin;
    logic            tmr_req;
    logic [2:0]      per_req;
    logic            insn_end;
    logic            ret_strobe;
    logic            wr_en;
    logic [2:0]      wr_sel;
    logic [NSRC-1:0] wr_data;
    logic [2:0]      rd_sel;
    logic [NSRC-1:0] rd_data;
    logic            irq_take;
    logic [15:0]     irq_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_req(tmr_req),
        .per_req(per_req), .insn_end(insn_end), .ret_strobe(ret_strobe),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_take(irq_take), .irq_vector(irq_vector)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_pin = '0; tmr_req = 0; per_req = '0; insn_end = 1'b1;
        ret_strobe = 0; wr_en = 0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [NSRC-1:0] d);
        @(negedge clk) begin wr_en = 1; wr_sel = sel; wr_data = d; end
        @(negedge clk) wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] sel, output int v);
        rd_sel = sel;
        #1 v = int'(rd_data);
    endtask

    task automatic do_ret();
        @(negedge clk) ret_strobe = 1;
        @(negedge clk) ret_strobe = 0;
    endtask

    task automatic wait_take(input int n, output bit got, output int vec);
        got = 0; vec = 0;
        for (int i = 0; i < n && !got; i++) begin
            @(negedge clk);
            if (irq_take) begin got = 1; vec = int'(irq_vector); end
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(3'd0, v); chk(v == 0, "R1 flags", v, 0);
        rd(3'd1, v); chk(v == 0, "R1 enables", v, 0);
        rd(3'd2, v); chk(v == 6'h3f, "R1 levels", v, 6'h3f);
        rd(3'd3, v); chk(v == 3, "R1 polarity", v, 3);
        rd(3'd4, v); chk(v == 0, "R1 control", v, 0);
        chk(irq_take == 0, "R1 take", int'(irq_take), 0);
    endtask

    task automatic t_periph_gate();
        bit g; int vec, v;
        do_reset();
        wr(3'd1, 6'b001000);
        wr(3'd4, 4'b0001);
        @(negedge clk) per_req = 3'b001;
        @(negedge clk) per_req = 3'b000;
        wait_take(10, g, vec); chk(!g, "R3 periph enable withheld", int'(g), 0);
        rd(3'd0, v); chk(v == 6'b001000, "R4 flag set by event", v, 6'b001000);
        wr(3'd4, 4'b0101);
        wait_take(5, g, vec); chk(g && vec == 8, "R2 single-level vector", vec, 8);
        rd(3'd4, v); chk(v == 4'b0100, "R6 global cleared on take", v, 4'b0100);
        do_ret();
        rd(3'd4, v); chk(v == 4'b0101, "R6 global restored on return", v, 4'b0101);
        wait_take(5, g, vec); chk(g, "R4 retaken with flag set", int'(g), 1);
        wr(3'd0, 6'b0);
        do_ret();
        wait_take(8, g, vec); chk(!g, "R4 no take after clear", int'(g), 0);
    endtask

    task automatic t_global_gate();
        bit g; int vec;
        do_reset();
        wr(3'd1, 6'b000100);
        wr(3'd4, 4'b0100);
        @(negedge clk) tmr_req = 1;
        @(negedge clk) tmr_req = 0;
        wait_take(8, g, vec); chk(!g, "R3 global withheld", int'(g), 0);
        wr(3'd4, 4'b0101);
        wait_take(5, g, vec); chk(g && vec == 8, "R3 global granted", vec, 8);
    endtask

    task automatic t_priority();
        bit g; int vec, v;
        do_reset();
        wr(3'd2, 6'b000100);
        wr(3'd1, 6'b001100);
        wr(3'd0, 6'b001100);
        wr(3'd4, 4'b1111);
        wait_take(5, g, vec); chk(g && vec == 8, "R5 high wins", vec, 8);
        rd(3'd4, v); chk(v == 4'b1110, "R6 high enable cleared", v, 4'b1110);
        wr(3'd0, 6'b001000);
        do_ret();
        wait_take(5, g, vec); chk(g && vec == 'h18, "R5 low vector", vec, 'h18);
        rd(3'd4, v); chk(v == 4'b1101, "R6 low enable cleared", v, 4'b1101);
        wr(3'd0, 6'b0);
        do_ret();
        rd(3'd4, v); chk(v == 4'b1111, "R6 low enable restored", v, 4'b1111);
    endtask

    task automatic t_nesting();
        bit g; int vec, v;
        do_reset();
        wr(3'd2, 6'b000100);
        wr(3'd1, 6'b001100);
        wr(3'd4, 4'b1111);
        @(negedge clk) per_req = 3'b001;
        @(negedge clk) per_req = 3'b000;
        wait_take(5, g, vec); chk(g && vec == 'h18, "R7 low handler entered", vec, 'h18);
        @(negedge clk) tmr_req = 1;
        @(negedge clk) tmr_req = 0;
        wait_take(5, g, vec); chk(g && vec == 8, "R7 high preempts", vec, 8);
        rd(3'd4, v); chk(v == 4'b1100, "R7 both levels masked", v, 4'b1100);
        wr(3'd0, 6'b001000);
        do_ret();
        rd(3'd4, v); chk(v == 4'b1101, "R7 first return high only", v, 4'b1101);
        wait_take(6, g, vec); chk(!g, "R7 low not retaken while running", int'(g), 0);
        wr(3'd0, 6'b0);
        do_ret();
        rd(3'd4, v); chk(v == 4'b1111, "R7 second return low", v, 4'b1111);
    endtask

    task automatic t_edge_rise();
        bit g; int vec, v;
        do_reset();
        wr(3'd1, 6'b000001);
        wr(3'd4, 4'b0001);
        @(negedge clk) ext_pin = 2'b01;
        wait_take(10, g, vec); chk(g && vec == 8, "R9 rising edge taken", vec, 8);
        rd(3'd0, v); chk(v == 1, "R9 rising flag", v, 1);
    endtask

    task automatic t_edge_fall();
        bit g; int vec, v;
        do_reset();
        wr(3'd3, 6'b000001);
        wr(3'd1, 6'b000010);
        wr(3'd4, 4'b0001);
        @(negedge clk) ext_pin = 2'b10;
        wait_take(8, g, vec); chk(!g, "R9 rise ignored when falling", int'(g), 0);
        rd(3'd0, v); chk(v == 0, "R9 no flag on rise", v, 0);
        @(negedge clk) ext_pin = 2'b00;
        wait_take(10, g, vec); chk(g && vec == 8, "R9 falling edge taken", vec, 8);
    endtask

    task automatic t_short_pulse();
        int v;
        do_reset();
        @(negedge clk) ext_pin = 2'b01;
        @(negedge clk) ext_pin = 2'b00;
        repeat (8) @(negedge clk);
        rd(3'd0, v); chk(v == 0, "R10 one-tick glitch rejected", v, 0);
        @(negedge clk) ext_pin = 2'b01;
        repeat (2) @(negedge clk);
        ext_pin = 2'b00;
        repeat (6) @(negedge clk);
        rd(3'd0, v); chk(v == 1, "R10 minimum width accepted", v, 1);
    endtask

    task automatic t_hw_wins();
        int v;
        do_reset();
        wr(3'd0, 6'b010000);
        @(negedge clk) begin wr_en = 1; wr_sel = 3'd0; wr_data = '0; per_req = 3'b010; end
        @(negedge clk) begin wr_en = 0; per_req = '0; end
        rd(3'd0, v); chk(v == 6'b010000, "R4 hardware set beats clear", v, 6'b010000);
    endtask

    task automatic t_boundary();
        bit g; int vec;
        do_reset();
        wr(3'd1, 6'b000100);
        insn_end = 0;
        wr(3'd0, 6'b000100);
        wr(3'd4, 4'b0001);
        wait_take(5, g, vec); chk(!g, "R8 held off without boundary", int'(g), 0);
        insn_end = 1;
        wait_take(3, g, vec); chk(g, "R8 taken at boundary", int'(g), 1);
        @(negedge clk); chk(irq_take == 0, "R8 single-cycle pulse", int'(irq_take), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_periph_gate();
        t_global_gate();
        t_priority();
        t_nesting();
        t_edge_rise();
        t_edge_fall();
        t_short_pulse();
        t_hw_wins();
        t_boundary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule